// File: doc/BRIEF.md
# Two-Stage Programmable Clock Divider

The block produces ten derived clock-like outputs from one reference clock, all in a single clock domain. A shared first stage divides the reference by 2, 4, 8 or 16 and yields a prescaled square wave. Each of the ten channels then divides that prescaled wave again, by any ratio from 1 to 32. A channel's waveform is set by a high-phase count and a low-phase count, each from 1 to 16 prescaled cycles. A divide-by-one bypass passes the prescaled wave straight through.

Software reaches the block in two ways. A byte-wide register port writes and reads the raw channel count bytes, the bypass flags and the prescale select. A configuration helper takes a channel, a divide ratio and a duty mode, and converts them into counts in one write. Requests outside the legal ranges are refused and flagged. Staged settings take effect only at the end of a channel's current output period, so no shortened pulse appears. An align pulse restarts the prescaler and every channel at once, which leaves all outputs phase-aligned.

Top module: `twostage_clkdiv`

## Requirements
- R1: The prescale select lives in bits 1:0 of register address 31: code 0 divides by 2, 1 by 4, 2 by 8 and 3 by 16. The prescaled wave is high for the first half of each period. A new select is used from the end of the current prescaled period, or from an align pulse.
- R2: Register address n (0 to 9) holds channel n's count byte: (low count − 1) in bits 7:4 and (high count − 1) in bits 3:0. A channel without bypass starts each period high, stays high for the high count of prescaled periods, then stays low for the low count.
- R3: Bit 7 of register address 16+n is channel n's bypass flag. While the flag is active, the channel output equals the prescaled wave: divide by one, 50% duty.
- R4: Helper duty mode 0 sets high = floor(ratio/2) and low = ratio − high.
- R5: Helper duty mode 1 sets high = 1 when the ratio is below 18, and ratio − 16 otherwise. Low = ratio − high.
- R6: Helper duty mode 2 sets low = 1 when the ratio is below 18, and ratio − 16 otherwise. High = ratio − low.
- R7: A helper request with ratio 1 sets the channel's bypass flag and leaves its count byte unchanged. Any other legal ratio clears the bypass flag in the same write that loads the new count byte.
- R8: A helper request is refused when the ratio is outside 1 to 32, the mode is 3, or the channel is 10 or above. A refused request changes no register, and cfg_err is high for exactly the cycle after it.
- R9: A channel copies its stored byte and bypass flag into its working setting only at the end of its output period (one prescaled period when bypassed) or on align. A write in mid-period leaves the current waveform untouched.
- R10: An align pulse restarts the prescaler and every channel at the start of a high phase on the next cycle, using the stored settings.
- R11: The read data follows rd_addr combinationally: count bytes as stored, {bypass, 0000000}, {000000, select}, and 0 for unused addresses. Reset clears every register, so all outputs are high just after reset.
- R12: When cfg_req and wr_en are asserted in the same cycle, only the helper request is acted on and the raw write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Raw register write strobe |
| wr_addr | input | 5 | Raw write address |
| wr_data | input | 8 | Raw write data |
| rd_addr | input | 5 | Read address |
| rd_data | output | 8 | Read data for rd_addr |
| cfg_req | input | 1 | Helper request strobe |
| cfg_chan | input | 4 | Helper target channel |
| cfg_ratio | input | 6 | Helper divide ratio |
| cfg_mode | input | 2 | Helper duty mode (0 half, 1 minimum, 2 maximum) |
| cfg_err | output | 1 | Pulse: previous helper request refused |
| align | input | 1 | Restart prescaler and all channels |
| div_out | output | 10 | Channel outputs |

## Verification
The embedded properties check the following on every cycle: the prescale counter stays inside its period, and each channel's phase position stays inside its ratio. A working setting changes only at a period end or an align. An align returns both the prescaler and the channel positions to zero. A refused request leaves the register bank untouched, and a legal non-unity request leaves the bypass flag clear. The actual waveform shapes can only be shown by the bench scenarios: high and low lengths per duty mode, the ratio 17/18 knee, bypass pass-through, select changes and mid-period reprogramming. The bench compares them with an independent behavioural model on every clock.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;
  parameter int unsigned FIELD_W = 4;
  localparam int unsigned RATIO_W = FIELD_W + 2;
  localparam int unsigned BYTE_W  = 2 * FIELD_W;

  typedef enum logic [1:0] {
    DUTY_HALF = 2'd0,
    DUTY_MIN  = 2'd1,
    DUTY_MAX  = 2'd2
  } duty_mode_e;

  typedef struct packed {
    logic               bypass;
    logic [FIELD_W-1:0] lo_m1;
    logic [FIELD_W-1:0] hi_m1;
  } chan_cfg_t;
endpackage

// File: rtl/pdiv_ratio_encoder.sv
module pdiv_ratio_encoder
  import pdiv_pkg::*;
(
  input  logic [RATIO_W-1:0] ratio,
  input  logic [1:0]         mode,
  output logic               ok,
  output chan_cfg_t          cfg
);
  localparam logic [RATIO_W-1:0] SPAN = RATIO_W'(1) << FIELD_W;
  localparam logic [RATIO_W-1:0] KNEE = SPAN + RATIO_W'(2);
  localparam logic [RATIO_W-1:0] MAXR = SPAN << 1;

  logic [RATIO_W-1:0] hi, lo, hi_m1_w, lo_m1_w, edge_cnt;

  always_comb begin
    ok = (ratio != '0) && (ratio <= MAXR) && (mode != 2'd3);
    edge_cnt = (ratio < KNEE) ? RATIO_W'(1) : (ratio - SPAN);
    case (duty_mode_e'(mode))
      DUTY_HALF: begin
        hi = ratio >> 1;
        lo = ratio - hi;
      end
      DUTY_MIN: begin
        hi = edge_cnt;
        lo = ratio - hi;
      end
      default: begin
        lo = edge_cnt;
        hi = ratio - lo;
      end
    endcase
    hi_m1_w    = hi - RATIO_W'(1);
    lo_m1_w    = lo - RATIO_W'(1);
    cfg.bypass = (ratio == RATIO_W'(1));
    cfg.hi_m1  = hi_m1_w[FIELD_W-1:0];
    cfg.lo_m1  = lo_m1_w[FIELD_W-1:0];
  end
endmodule

// File: rtl/pdiv_prescaler.sv
module pdiv_prescaler #(
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_req,
  input  logic             restart,
  output logic             tick_end,
  output logic             lvl
);
  localparam int unsigned CNT_W = 1 << SEL_W;

  logic [CNT_W-1:0] cnt_q, cnt_d, last, half;
  logic [SEL_W-1:0] sel_q, sel_d;

  always_comb begin
    last     = CNT_W'((2 << sel_q) - 1);
    half     = CNT_W'(1 << sel_q);
    tick_end = (cnt_q == last);
    lvl      = (cnt_q < half);
  end

  always_comb begin
    if (restart || tick_end) begin
      cnt_d = '0;
      sel_d = sel_req;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
      sel_d = sel_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sel_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      sel_q <= sel_d;
    end
  end

  // R1: the counter never passes the end of its period
  a_r1_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last);
  // R1: the select is held inside a prescaled period
  a_r1_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(restart || tick_end) |=> $stable(sel_q));
  // R10: align restarts the prescaler
  a_r10_presc_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));
endmodule

// File: rtl/pdiv_channel.sv
module pdiv_channel
  import pdiv_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick_end,
  input  logic      restart,
  input  logic      presc_lvl,
  input  chan_cfg_t stored,
  output logic      out
);
  chan_cfg_t          act_q, act_d;
  logic [RATIO_W-1:0] pos_q, pos_d, last_pos, hi_ext;
  logic               wrap, load, adv;

  always_comb begin
    hi_ext   = RATIO_W'(act_q.hi_m1);
    last_pos = hi_ext + RATIO_W'(act_q.lo_m1) + RATIO_W'(1);
    wrap     = tick_end && (act_q.bypass || (pos_q == last_pos));
    load     = restart || wrap;
    adv      = tick_end && !wrap;
    out      = act_q.bypass ? presc_lvl : (pos_q <= hi_ext);
  end

  always_comb begin
    act_d = act_q;
    pos_d = pos_q;
    if (load) begin
      act_d = stored;
      pos_d = '0;
    end else if (adv) begin
      pos_d = pos_q + RATIO_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
      pos_q <= '0;
    end else begin
      act_q <= act_d;
      pos_q <= pos_d;
    end
  end

  // R9: working setting changes only at a period end or align
  a_r9_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wrap || restart) |=> $stable(act_q));
  // R2: position stays inside the programmed period
  a_r2_pos_in_period: assert property (@(posedge clk) disable iff (!rst_n)
    !act_q.bypass |-> (pos_q <= last_pos));
  // R3: a bypassed channel never leaves position zero
  a_r3_bypass_pos: assert property (@(posedge clk) disable iff (!rst_n)
    act_q.bypass |-> (pos_q == '0));
  // R10: align restarts the channel at a high phase
  a_r10_chan_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (pos_q == '0));
endmodule

// File: rtl/twostage_clkdiv.sv
module twostage_clkdiv
  import pdiv_pkg::*;
#(
  parameter  int unsigned NUM_CH = 10,
  parameter  int unsigned SEL_W  = 2,
  parameter  int unsigned ADDR_W = 5,
  localparam int unsigned CH_W   = $clog2(NUM_CH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [BYTE_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [BYTE_W-1:0]  rd_data,
  input  logic               cfg_req,
  input  logic [CH_W-1:0]    cfg_chan,
  input  logic [RATIO_W-1:0] cfg_ratio,
  input  logic [1:0]         cfg_mode,
  output logic               cfg_err,
  input  logic               align,
  output logic [NUM_CH-1:0]  div_out
);
  localparam int unsigned BYP_BASE = 1 << (ADDR_W - 1);
  localparam int unsigned SEL_ADDR = (1 << ADDR_W) - 1;

  logic [NUM_CH-1:0][BYTE_W-1:0] cnt_q, cnt_d;
  logic [NUM_CH-1:0]             byp_q, byp_d, req_hot;
  logic [SEL_W-1:0]              sel_q, sel_d;
  logic                          err_d, enc_ok, req_ok, tick_end, presc_lvl;
  chan_cfg_t                     enc_cfg;

  pdiv_ratio_encoder u_enc (
    .ratio (cfg_ratio),
    .mode  (cfg_mode),
    .ok    (enc_ok),
    .cfg   (enc_cfg)
  );

  always_comb begin
    req_ok = cfg_req && enc_ok && (int'(cfg_chan) < NUM_CH);
    err_d  = cfg_req && !req_ok;
    cnt_d  = cnt_q;
    byp_d  = byp_q;
    sel_d  = sel_q;
    for (int i = 0; i < NUM_CH; i++) begin
      req_hot[i] = (int'(cfg_chan) == i);
      if (cfg_req) begin
        if (req_ok && req_hot[i]) begin
          if (enc_cfg.bypass) begin
            byp_d[i] = 1'b1;
          end else begin
            byp_d[i] = 1'b0;
            cnt_d[i] = {enc_cfg.lo_m1, enc_cfg.hi_m1};
          end
        end
      end else if (wr_en) begin
        if (int'(wr_addr) == i)            cnt_d[i] = wr_data;
        if (int'(wr_addr) == BYP_BASE + i) byp_d[i] = wr_data[BYTE_W-1];
      end
    end
    if (!cfg_req && wr_en && (int'(wr_addr) == SEL_ADDR)) sel_d = wr_data[SEL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      byp_q   <= '0;
      sel_q   <= '0;
      cfg_err <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      byp_q   <= byp_d;
      sel_q   <= sel_d;
      cfg_err <= err_d;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (int'(rd_addr) == i)            rd_data = cnt_q[i];
      if (int'(rd_addr) == BYP_BASE + i) rd_data = {byp_q[i], {(BYTE_W-1){1'b0}}};
    end
    if (int'(rd_addr) == SEL_ADDR) rd_data = BYTE_W'(sel_q);
  end

  pdiv_prescaler #(.SEL_W(SEL_W)) u_presc (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_req  (sel_q),
    .restart  (align),
    .tick_end (tick_end),
    .lvl      (presc_lvl)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    chan_cfg_t stored;
    always_comb begin
      stored.bypass = byp_q[g];
      stored.lo_m1  = cnt_q[g][BYTE_W-1:FIELD_W];
      stored.hi_m1  = cnt_q[g][FIELD_W-1:0];
    end
    pdiv_channel u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_end  (tick_end),
      .restart   (align),
      .presc_lvl (presc_lvl),
      .stored    (stored),
      .out       (div_out[g])
    );
  end

  // R8: a refused request leaves the register bank untouched
  a_r8_reject_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && !req_ok) |=> ($stable(cnt_q) && $stable(byp_q) && $stable(sel_q)));
  // R8: the error flag only follows a request
  a_r8_err_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> $past(cfg_req));
  // R7: a legal non-unity request leaves the bypass flag clear
  a_r7_bypass_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ok && !enc_cfg.bypass) |=> ((byp_q & $past(req_hot)) == '0));
  // R12: a helper request blocks a raw select write
  a_r12_req_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && wr_en && (int'(wr_addr) == SEL_ADDR)) |=> $stable(sel_q));
endmodule

// File: tb/twostage_clkdiv_test.sv
module twostage_clkdiv_test;
  timeunit 1ns;
  timeprecision 1ns;

  localparam int CLK_PERIOD = 10;
  localparam int NCH        = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk, rst_n, wr_en, cfg_req, cfg_err, align;
  logic [4:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic [3:0] cfg_chan;
  logic [5:0] cfg_ratio;
  logic [1:0] cfg_mode;
  logic [9:0] div_out;

  int checks = 0, fails = 0, cycles = 0;
  string cur_tag = "R11";

  twostage_clkdiv uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .cfg_req(cfg_req), .cfg_chan(cfg_chan),
    .cfg_ratio(cfg_ratio), .cfg_mode(cfg_mode), .cfg_err(cfg_err), .align(align),
    .div_out(div_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  int m_sel, m_sela, m_pcnt;
  int m_cnt[NCH], m_byp[NCH], m_hi[NCH], m_lo[NCH], m_ab[NCH], m_pos[NCH];
  int m_err;

  function automatic void encode(input int r, input int md, output int h, output int l);
    int e;
    e = (r < 18) ? 1 : r - 16;
    if (md == 0) begin h = r / 2; l = r - h; end       // R4
    else if (md == 1) begin h = e; l = r - h; end      // R5
    else begin l = e; h = r - l; end                   // R6
  endfunction

  function automatic int exp_rd(input int a);
    if (a < NCH) return m_cnt[a];
    if (a >= 16 && a - 16 < NCH) return m_byp[a-16] * 128;
    if (a == 31) return m_sel;
    return 0;
  endfunction

  task automatic m_reset();
    m_sel = 0; m_sela = 0; m_pcnt = 0; m_err = 0;
    for (int i = 0; i < NCH; i++) begin
      m_cnt[i] = 0; m_byp[i] = 0; m_hi[i] = 1; m_lo[i] = 1; m_ab[i] = 0; m_pos[i] = 0;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      fails++;
      $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WATCHDOG);
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
    if (!rst_n) m_reset();
    else begin
      int per, tend, h, l, ok;
      per  = 2 << m_sela;
      tend = (m_pcnt == per - 1);
      for (int i = 0; i < NCH; i++) begin
        int w;
        w = tend && (m_ab[i] != 0 || m_pos[i] == m_hi[i] + m_lo[i] - 1);
        if (align || w) begin
          m_pos[i] = 0; m_hi[i] = (m_cnt[i] % 16) + 1; m_lo[i] = (m_cnt[i] / 16) + 1;
          m_ab[i] = m_byp[i];
        end else if (tend) m_pos[i]++;
      end
      if (align || tend) begin m_pcnt = 0; m_sela = m_sel; end
      else m_pcnt++;
      if (cfg_req) begin
        ok = (cfg_ratio >= 1) && (cfg_ratio <= 32) && (cfg_mode != 3) && (cfg_chan < NCH);
        m_err = !ok;
        if (ok) begin
          if (cfg_ratio == 1) m_byp[cfg_chan] = 1;
          else begin
            encode(int'(cfg_ratio), int'(cfg_mode), h, l);
            m_byp[cfg_chan] = 0;
            m_cnt[cfg_chan] = (l - 1) * 16 + (h - 1);
          end
        end
      end else begin
        m_err = 0;
        if (wr_en) begin
          if (wr_addr < NCH) m_cnt[wr_addr] = wr_data;
          if (wr_addr >= 16 && wr_addr - 16 < NCH) m_byp[wr_addr-16] = wr_data[7];
          if (wr_addr == 31) m_sel = wr_data % 4;
        end
      end
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      int ev, plvl;
      plvl = (m_pcnt < (1 << m_sela));
      ev = 0;
      for (int i = 0; i < NCH; i++)
        if (m_ab[i] != 0 ? plvl : (m_pos[i] < m_hi[i])) ev |= (1 << i);
      chk(cur_tag, "div_out", int'(div_out), ev);
      chk("R8", "cfg_err", int'(cfg_err), m_err);
      chk("R11", "rd_data", int'(rd_data), exp_rd(int'(rd_addr)));
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
    cfg_req = 0; wr_en = 0; align = 0;
    rd_addr = rd_addr + 5'd1;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic do_cfg(input int ch, input int r, input int md);
    cfg_chan = 4'(ch); cfg_ratio = 6'(r); cfg_mode = 2'(md); cfg_req = 1;
    cyc();
  endtask

  task automatic do_wr(input int a, input int d);
    wr_addr = 5'(a); wr_data = 8'(d); wr_en = 1;
    cyc();
  endtask

  task automatic do_align();
    align = 1;
    cyc();
  endtask

  initial begin
    rst_n = 0; wr_en = 0; cfg_req = 0; align = 0;
    wr_addr = 0; wr_data = 0; rd_addr = 0; cfg_chan = 0; cfg_ratio = 0; cfg_mode = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset state
    chk("R11", "reset div_out", int'(div_out), 10'h3FF);
    chk("R11", "reset rd_data", int'(rd_data), 0);
    chk("R11", "reset cfg_err", int'(cfg_err), 0);
    @(posedge clk); #1 rst_n = 1;
    run(20);

    cur_tag = "R2";   // raw count byte: high 2, low 3
    do_wr(9, 8'h21); run(200);

    cur_tag = "R4";
    do_cfg(0, 5, 0); do_cfg(6, 32, 0); do_align(); run(400);

    cur_tag = "R5";   // includes the 17/18 knee
    do_cfg(1, 7, 1); do_cfg(2, 20, 1); do_cfg(7, 17, 1); run(600);

    cur_tag = "R6";
    do_cfg(3, 7, 2); do_cfg(4, 20, 2); do_cfg(8, 18, 2); do_align(); run(600);

    cur_tag = "R7";
    do_cfg(5, 1, 0); run(100); do_cfg(5, 4, 0); run(200);
    do_wr(18, 8'h80); run(100); do_cfg(2, 3, 0); run(100);

    cur_tag = "R3";
    do_cfg(5, 1, 2); do_wr(16 + 9, 8'hFF); run(300);

    cur_tag = "R1";
    do_wr(31, 1); run(800);
    do_wr(31, 2); run(1500);
    do_wr(31, 3); run(3000);

    cur_tag = "R9";   // mid-period reprogramming without align
    run(37); do_cfg(6, 9, 1); do_cfg(0, 2, 0); run(2000);

    cur_tag = "R10";
    do_wr(31, 2); run(13); do_align(); run(71); do_align(); run(400);
    do_wr(31, 0); do_align(); run(300);

    cur_tag = "R8";
    do_cfg(1, 0, 0);  run(5);
    do_cfg(1, 33, 0); run(5);
    do_cfg(1, 6, 3);  run(5);
    do_cfg(10, 6, 0); run(5);
    do_cfg(15, 1, 0); run(5);

    cur_tag = "R12";
    wr_addr = 5'd31; wr_data = 8'h03; wr_en = 1;
    do_cfg(1, 3, 0); run(40);
    wr_addr = 5'd0; wr_data = 8'hFF; wr_en = 1;
    do_cfg(0, 6, 2); run(200);

    cur_tag = "R11";
    run(64);

    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule